// File: doc/BRIEF.md
# Paired-Field Pointer Access Window

This block lets a host reach seven 8-bit calendar fields through two byte ports, a high port and a low port. A 2-bit pointer picks which pair of fields the ports show. There are two copies of the window, one for the running time fields and one for the alarm fields. Each copy has its own pointer, and a one-bit window select chooses which copy the host is addressing. The block does not store any field values. It turns host accesses into per-field read and write strobes, passes the write byte through, and muxes the current field values back onto the read ports. The counters and the alarm comparison logic sit outside this block.

Each pointer is a four-state machine. The states are PTR_MIN_SEC (00), PTR_WDAY_HOUR (01), PTR_MON_DAY (10) and PTR_YEAR (11). A pointer-load write moves the selected machine straight to any state. An access to the high port takes the step transition (11→10→01→00). PTR_MIN_SEC holds on a high access. Any other cycle leaves the state unchanged. Because of this, a host can load 11 and then alternate low and high accesses to walk through year, month/day, weekday/hour and minutes/seconds, and the window then stays on minutes/seconds.

Top module: `regwin_pair`

## Requirements
- R1: After reset, both pointers are 00, all read and write strobes are low, and the ports show the minutes (high) and seconds (low) of the selected window.
- R2: A pointer-load cycle sets the selected window's pointer to `ptr_value` on the next edge. If a high access happens in the same cycle, the load wins, but the access still produces its strobes.
- R3: Field i occupies bits [8i+7:8i] of a field bus, with seconds=0, minutes=1, hours=2, weekday=3, day=4, month=5 and year=6. Pointer 00 shows minutes/seconds, 01 shows weekday/hours, 10 shows month/day, and 11 shows an unused high byte with year on the low port.
- R4: A high-port read, a high-port write, or both in the same cycle lowers the selected pointer by exactly one on the next edge.
- R5: With the pointer at 00, a high-port access leaves it at 00.
- R6: Low-port accesses never change either pointer.
- R7: At pointer 11 the high port reads 00h, and a read or write of it raises no strobe.
- R8: A write strobe (bit i of `tm_wr_stb` or `al_wr_stb`) fires for the addressed field only while `wr_enable` is high. A blocked high-port write still lowers the pointer.
- R9: A read strobe fires in the same cycle as the read, on the bit of the field the port shows.
- R10: An access or load aimed at one window leaves the other window's pointer and strobes untouched. The read ports show the window chosen by `win_sel` (0 = time, 1 = alarm).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_enable | input | 1 | Allows window writes to reach the fields |
| win_sel | input | 1 | 0 selects the time window, 1 selects the alarm window |
| ptr_load | input | 1 | Loads the selected window's pointer |
| ptr_value | input | 2 | Value to load into the pointer |
| hi_rd | input | 1 | High-port read |
| hi_wr | input | 1 | High-port write |
| lo_rd | input | 1 | Low-port read |
| lo_wr | input | 1 | Low-port write |
| wdata | input | 8 | Host write byte |
| tm_fields | input | 56 | Current time field values (layout per R3) |
| al_fields | input | 56 | Current alarm field values (layout per R3) |
| rdata_hi | output | 8 | High-port read data |
| rdata_lo | output | 8 | Low-port read data |
| tm_rd_stb | output | 7 | Time field read strobes |
| tm_wr_stb | output | 7 | Time field write strobes |
| al_rd_stb | output | 7 | Alarm field read strobes |
| al_wr_stb | output | 7 | Alarm field write strobes |
| fld_wdata | output | 8 | Write byte for the strobed field |
| tm_ptr | output | 2 | Time window pointer |
| al_ptr | output | 2 | Alarm window pointer |

## Verification
The one-hot read-strobe property assumes the host never touches the high port and the low port of the same window in the same cycle. The stimulus table only ever combines the high-port read with the high-port write, which is the one pairing the design treats as a single access. The properties also take the field buses as stable within a cycle, since they compare read data with the bus in the same cycle. The bench holds both buses at fixed, distinct patterns so that every field and every window can be told apart on the read ports.

// File: rtl/regwin_pkg.sv
package regwin_pkg;
    localparam int PTR_W      = 2;
    localparam int NUM_FIELDS = 7;
    localparam int IDX_W      = $clog2(NUM_FIELDS);

    localparam int F_SEC  = 0;
    localparam int F_MIN  = 1;
    localparam int F_HOUR = 2;
    localparam int F_WDAY = 3;
    localparam int F_DAY  = 4;
    localparam int F_MON  = 5;
    localparam int F_YEAR = 6;

    typedef enum logic [PTR_W-1:0] {
        PTR_MIN_SEC   = 2'b00,
        PTR_WDAY_HOUR = 2'b01,
        PTR_MON_DAY   = 2'b10,
        PTR_YEAR      = 2'b11
    } win_ptr_e;

    typedef struct packed {
        logic hi_rd;
        logic hi_wr;
        logic lo_rd;
        logic lo_wr;
    } win_acc_t;
endpackage

// File: rtl/win_ptr_fsm.sv
module win_ptr_fsm
    import regwin_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [PTR_W-1:0] load_val,
    input  logic             hi_acc,
    output win_ptr_e         ptr
);
    win_ptr_e ptr_next;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) ptr <= PTR_MIN_SEC;
        else        ptr <= ptr_next;
    end

    // transitions: load beats step; step walks toward PTR_MIN_SEC and holds there
    always_comb begin
        ptr_next = ptr;
        if (load) begin
            ptr_next = win_ptr_e'(load_val);
        end else if (hi_acc) begin
            unique case (ptr)
                PTR_YEAR:      ptr_next = PTR_MON_DAY;
                PTR_MON_DAY:   ptr_next = PTR_WDAY_HOUR;
                PTR_WDAY_HOUR: ptr_next = PTR_MIN_SEC;
                PTR_MIN_SEC:   ptr_next = PTR_MIN_SEC;
            endcase
        end
    end
endmodule

// File: rtl/win_field_map.sv
module win_field_map
    import regwin_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  win_ptr_e                     ptr,
    input  win_acc_t                     acc,
    input  logic                         wr_enable,
    input  logic [NUM_FIELDS*DATA_W-1:0] fields,
    output logic [DATA_W-1:0]            rdata_hi,
    output logic [DATA_W-1:0]            rdata_lo,
    output logic [NUM_FIELDS-1:0]        rd_stb,
    output logic [NUM_FIELDS-1:0]        wr_stb
);
    logic             hi_used;
    logic [IDX_W-1:0] hi_idx;
    logic [IDX_W-1:0] lo_idx;

    // pair selected by each pointer state
    always_comb begin
        hi_used = 1'b1;
        hi_idx  = '0;
        lo_idx  = '0;
        unique case (ptr)
            PTR_MIN_SEC:   begin hi_idx = IDX_W'(F_MIN);  lo_idx = IDX_W'(F_SEC);  end
            PTR_WDAY_HOUR: begin hi_idx = IDX_W'(F_WDAY); lo_idx = IDX_W'(F_HOUR); end
            PTR_MON_DAY:   begin hi_idx = IDX_W'(F_MON);  lo_idx = IDX_W'(F_DAY);  end
            PTR_YEAR:      begin hi_used = 1'b0;          lo_idx = IDX_W'(F_YEAR); end
        endcase
    end

    // outputs: read mux and strobes
    always_comb begin
        rdata_hi = hi_used ? fields[hi_idx*DATA_W +: DATA_W] : '0;
        rdata_lo = fields[lo_idx*DATA_W +: DATA_W];
        rd_stb   = '0;
        wr_stb   = '0;
        if (acc.hi_rd && hi_used)              rd_stb[hi_idx] = 1'b1;
        if (acc.lo_rd)                         rd_stb[lo_idx] = 1'b1;
        if (acc.hi_wr && hi_used && wr_enable) wr_stb[hi_idx] = 1'b1;
        if (acc.lo_wr && wr_enable)            wr_stb[lo_idx] = 1'b1;
    end
endmodule

// File: rtl/win_channel.sv
module win_channel
    import regwin_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         sel,
    input  logic                         wr_enable,
    input  logic                         ptr_load,
    input  logic [PTR_W-1:0]             ptr_value,
    input  win_acc_t                     acc_in,
    input  logic [NUM_FIELDS*DATA_W-1:0] fields,
    output logic [DATA_W-1:0]            rdata_hi,
    output logic [DATA_W-1:0]            rdata_lo,
    output logic [NUM_FIELDS-1:0]        rd_stb,
    output logic [NUM_FIELDS-1:0]        wr_stb,
    output logic [PTR_W-1:0]             ptr_out
);
    win_acc_t acc;
    win_ptr_e ptr;

    assign acc     = sel ? acc_in : '0;
    assign ptr_out = ptr;

    win_ptr_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (sel && ptr_load),
        .load_val (ptr_value),
        .hi_acc   (acc.hi_rd || acc.hi_wr),
        .ptr      (ptr)
    );

    win_field_map #(.DATA_W(DATA_W)) u_map (
        .ptr       (ptr),
        .acc       (acc),
        .wr_enable (wr_enable),
        .fields    (fields),
        .rdata_hi  (rdata_hi),
        .rdata_lo  (rdata_lo),
        .rd_stb    (rd_stb),
        .wr_stb    (wr_stb)
    );
endmodule

// File: rtl/regwin_pair.sv
module regwin_pair
    import regwin_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_enable,
    input  logic                         win_sel,
    input  logic                         ptr_load,
    input  logic [PTR_W-1:0]             ptr_value,
    input  logic                         hi_rd,
    input  logic                         hi_wr,
    input  logic                         lo_rd,
    input  logic                         lo_wr,
    input  logic [DATA_W-1:0]            wdata,
    input  logic [NUM_FIELDS*DATA_W-1:0] tm_fields,
    input  logic [NUM_FIELDS*DATA_W-1:0] al_fields,
    output logic [DATA_W-1:0]            rdata_hi,
    output logic [DATA_W-1:0]            rdata_lo,
    output logic [NUM_FIELDS-1:0]        tm_rd_stb,
    output logic [NUM_FIELDS-1:0]        tm_wr_stb,
    output logic [NUM_FIELDS-1:0]        al_rd_stb,
    output logic [NUM_FIELDS-1:0]        al_wr_stb,
    output logic [DATA_W-1:0]            fld_wdata,
    output logic [PTR_W-1:0]             tm_ptr,
    output logic [PTR_W-1:0]             al_ptr
);
    localparam int NUM_WIN = 2;
    localparam int FBUS_W  = NUM_FIELDS * DATA_W;

    win_acc_t                        acc;
    logic [NUM_WIN-1:0][FBUS_W-1:0]  fbus;
    logic [NUM_WIN-1:0][DATA_W-1:0]  hi_w, lo_w;
    logic [NUM_WIN-1:0][NUM_FIELDS-1:0] rd_w, wr_w;
    logic [NUM_WIN-1:0][PTR_W-1:0]   ptr_w;

    assign acc       = '{hi_rd: hi_rd, hi_wr: hi_wr, lo_rd: lo_rd, lo_wr: lo_wr};
    assign fbus[0]   = tm_fields;
    assign fbus[1]   = al_fields;
    assign fld_wdata = wdata;

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        win_channel #(.DATA_W(DATA_W)) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .sel       (win_sel == 1'(w)),
            .wr_enable (wr_enable),
            .ptr_load  (ptr_load),
            .ptr_value (ptr_value),
            .acc_in    (acc),
            .fields    (fbus[w]),
            .rdata_hi  (hi_w[w]),
            .rdata_lo  (lo_w[w]),
            .rd_stb    (rd_w[w]),
            .wr_stb    (wr_w[w]),
            .ptr_out   (ptr_w[w])
        );
    end

    assign rdata_hi  = hi_w[win_sel];
    assign rdata_lo  = lo_w[win_sel];
    assign tm_rd_stb = rd_w[0];
    assign tm_wr_stb = wr_w[0];
    assign al_rd_stb = rd_w[1];
    assign al_wr_stb = wr_w[1];
    assign tm_ptr    = ptr_w[0];
    assign al_ptr    = ptr_w[1];
endmodule

// File: rtl/regwin_pair_chk.sv
module regwin_pair_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_enable,
    input logic        win_sel,
    input logic        ptr_load,
    input logic [1:0]  ptr_value,
    input logic        hi_rd,
    input logic        hi_wr,
    input logic        lo_rd,
    input logic        lo_wr,
    input logic [55:0] tm_fields,
    input logic [7:0]  rdata_hi,
    input logic [7:0]  rdata_lo,
    input logic [6:0]  tm_rd_stb,
    input logic [6:0]  tm_wr_stb,
    input logic [6:0]  al_rd_stb,
    input logic [6:0]  al_wr_stb,
    input logic [1:0]  tm_ptr,
    input logic [1:0]  al_ptr
);
    logic hi_any, tm_ld, al_ld;
    assign hi_any = hi_rd || hi_wr;
    assign tm_ld  = ptr_load && !win_sel;
    assign al_ld  = ptr_load && win_sel;

    AST_LOAD_TM: assert property (@(posedge clk) disable iff (!rst_n)
        tm_ld |=> tm_ptr == $past(ptr_value)); // R2
    AST_STEP_TM: assert property (@(posedge clk) disable iff (!rst_n)
        (!win_sel && hi_any && !tm_ld && tm_ptr != 2'd0) |=> tm_ptr == 2'($past(tm_ptr) - 2'd1)); // R4
    AST_FLOOR_AL: assert property (@(posedge clk) disable iff (!rst_n)
        (win_sel && hi_any && !al_ld && al_ptr == 2'd0) |=> al_ptr == 2'd0); // R5
    AST_HOLD_TM: assert property (@(posedge clk) disable iff (!rst_n)
        (!(!win_sel && hi_any) && !tm_ld) |=> $stable(tm_ptr)); // R6
    AST_HOLD_AL: assert property (@(posedge clk) disable iff (!rst_n)
        (!(win_sel && hi_any) && !al_ld) |=> $stable(al_ptr)); // R10
    AST_UNUSED_HI: assert property (@(posedge clk) disable iff (!rst_n)
        (!win_sel && tm_ptr == 2'd3) |-> (rdata_hi == 8'h00 && !tm_rd_stb[1] && !tm_rd_stb[3] && !tm_rd_stb[5])); // R7
    AST_MAP_MS: assert property (@(posedge clk) disable iff (!rst_n)
        (!win_sel && tm_ptr == 2'd0) |-> (rdata_lo == tm_fields[7:0] && rdata_hi == tm_fields[15:8])); // R3
    AST_WR_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_enable |-> (tm_wr_stb == 7'd0 && al_wr_stb == 7'd0)); // R8
    AST_RD_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        !(hi_any && (lo_rd || lo_wr)) |-> ($onehot0(tm_rd_stb) && $onehot0(al_rd_stb))); // R9
    AST_IDLE_STB: assert property (@(posedge clk) disable iff (!rst_n)
        win_sel |-> (tm_rd_stb == 7'd0 && tm_wr_stb == 7'd0)); // R10
endmodule

bind regwin_pair regwin_pair_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_enable (wr_enable),
    .win_sel   (win_sel),
    .ptr_load  (ptr_load),
    .ptr_value (ptr_value),
    .hi_rd     (hi_rd),
    .hi_wr     (hi_wr),
    .lo_rd     (lo_rd),
    .lo_wr     (lo_wr),
    .tm_fields (tm_fields),
    .rdata_hi  (rdata_hi),
    .rdata_lo  (rdata_lo),
    .tm_rd_stb (tm_rd_stb),
    .tm_wr_stb (tm_wr_stb),
    .al_rd_stb (al_rd_stb),
    .al_wr_stb (al_wr_stb),
    .tm_ptr    (tm_ptr),
    .al_ptr    (al_ptr)
);

// File: tb/sim_regwin_pair.sv
module sim_regwin_pair;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 14;

    typedef struct packed {
        logic       win;
        logic       ld;
        logic [1:0] pv;
        logic       hr, hw, lr, lw, we;
        logic [7:0] wd;
        logic [7:0] e_hi, e_lo;
        logic [6:0] e_trd, e_twr, e_ard, e_awr;
        logic [1:0] e_tp, e_ap;
    } vec_t;

    // win ld pv hr hw lr lw we wd | hi lo | trd twr ard awr | tp ap
    localparam vec_t VECS [NVEC] = '{
        '{1'b0,1'b1,2'd3,1'b0,1'b0,1'b0,1'b0,1'b0,8'h00, 8'h59,8'h45, 7'h00,7'h00,7'h00,7'h00, 2'd3,2'd0},
        '{1'b0,1'b0,2'd0,1'b1,1'b0,1'b0,1'b0,1'b0,8'h00, 8'h00,8'h24, 7'h00,7'h00,7'h00,7'h00, 2'd2,2'd0},
        '{1'b0,1'b0,2'd0,1'b0,1'b0,1'b1,1'b0,1'b0,8'h00, 8'h12,8'h31, 7'h10,7'h00,7'h00,7'h00, 2'd2,2'd0},
        '{1'b0,1'b0,2'd0,1'b0,1'b1,1'b0,1'b0,1'b1,8'hAA, 8'h12,8'h31, 7'h00,7'h20,7'h00,7'h00, 2'd1,2'd0},
        '{1'b0,1'b0,2'd0,1'b0,1'b1,1'b0,1'b0,1'b0,8'h55, 8'h03,8'h23, 7'h00,7'h00,7'h00,7'h00, 2'd0,2'd0},
        '{1'b0,1'b0,2'd0,1'b1,1'b0,1'b0,1'b0,1'b0,8'h00, 8'h59,8'h45, 7'h02,7'h00,7'h00,7'h00, 2'd0,2'd0},
        '{1'b1,1'b1,2'd2,1'b0,1'b0,1'b0,1'b0,1'b0,8'h00, 8'h30,8'h10, 7'h00,7'h00,7'h00,7'h00, 2'd0,2'd2},
        '{1'b1,1'b0,2'd0,1'b0,1'b0,1'b0,1'b1,1'b1,8'h07, 8'h11,8'h15, 7'h00,7'h00,7'h00,7'h10, 2'd0,2'd2},
        '{1'b1,1'b1,2'd3,1'b1,1'b0,1'b0,1'b0,1'b0,8'h00, 8'h11,8'h15, 7'h00,7'h00,7'h20,7'h00, 2'd0,2'd3},
        '{1'b1,1'b0,2'd0,1'b0,1'b1,1'b0,1'b0,1'b1,8'h3C, 8'h00,8'h99, 7'h00,7'h00,7'h00,7'h00, 2'd0,2'd2},
        '{1'b0,1'b0,2'd0,1'b0,1'b0,1'b0,1'b1,1'b1,8'h01, 8'h59,8'h45, 7'h00,7'h01,7'h00,7'h00, 2'd0,2'd2},
        '{1'b1,1'b0,2'd0,1'b1,1'b1,1'b0,1'b0,1'b1,8'h08, 8'h11,8'h15, 7'h00,7'h00,7'h20,7'h20, 2'd0,2'd1},
        '{1'b1,1'b0,2'd0,1'b1,1'b0,1'b0,1'b0,1'b0,8'h00, 8'h06,8'h07, 7'h00,7'h00,7'h08,7'h00, 2'd0,2'd0},
        '{1'b1,1'b0,2'd0,1'b1,1'b0,1'b0,1'b0,1'b0,8'h00, 8'h30,8'h10, 7'h00,7'h00,7'h02,7'h00, 2'd0,2'd0}
    };

    logic clk = 1'b0;
    logic rst_n;
    logic wr_enable, win_sel, ptr_load, hi_rd, hi_wr, lo_rd, lo_wr;
    logic [1:0] ptr_value, tm_ptr, al_ptr;
    logic [7:0] wdata, rdata_hi, rdata_lo, fld_wdata;
    logic [55:0] tm_fields, al_fields;
    logic [6:0] tm_rd_stb, tm_wr_stb, al_rd_stb, al_wr_stb;
    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    regwin_pair u0 (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        {ptr_load, hi_rd, hi_wr, lo_rd, lo_wr, wr_enable} = '0;
        ptr_value = 2'd0; wdata = 8'h00; win_sel = 1'b0;
    endtask

    initial begin
        // sec=45 min=59 hour=23 wday=03 day=31 month=12 year=24
        tm_fields = 56'h24_12_31_03_23_59_45;
        al_fields = 56'h99_11_15_06_07_30_10;
        idle();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1 tm_ptr", 32'(tm_ptr), 32'd0);
        check("R1 al_ptr", 32'(al_ptr), 32'd0);
        check("R1 strobes", 32'({tm_rd_stb, tm_wr_stb, al_rd_stb, al_wr_stb}), 32'd0);
        check("R1 rdata", 32'({rdata_hi, rdata_lo}), 32'h5945);

        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            win_sel = VECS[i].win; ptr_load = VECS[i].ld; ptr_value = VECS[i].pv;
            hi_rd = VECS[i].hr; hi_wr = VECS[i].hw; lo_rd = VECS[i].lr; lo_wr = VECS[i].lw;
            wr_enable = VECS[i].we; wdata = VECS[i].wd;
            #1;
            check("R3 R7 R10 rdata", 32'({rdata_hi, rdata_lo}), 32'({VECS[i].e_hi, VECS[i].e_lo}));
            check("R7 R9 R10 rd_stb", 32'({tm_rd_stb, al_rd_stb}), 32'({VECS[i].e_trd, VECS[i].e_ard}));
            check("R8 R10 wr_stb", 32'({tm_wr_stb, al_wr_stb}), 32'({VECS[i].e_twr, VECS[i].e_awr}));
            if (VECS[i].we) check("R8 fld_wdata", 32'(fld_wdata), 32'(VECS[i].wd));
            @(posedge clk);
            #1;
            check("R2 R4 R5 R6 R10 ptrs", 32'({tm_ptr, al_ptr}), 32'({VECS[i].e_tp, VECS[i].e_ap}));
        end

        // directed: low write at pointer 11 reaches year, pointer unchanged (R6 R3)
        @(negedge clk);
        idle(); ptr_load = 1'b1; ptr_value = 2'd3;
        @(negedge clk);
        idle(); lo_wr = 1'b1; wr_enable = 1'b1;
        #1;
        check("R3 year wr_stb", 32'(tm_wr_stb), 32'h40);
        @(posedge clk); #1;
        check("R6 ptr after low write", 32'(tm_ptr), 32'd3);

        // directed: reset in mid-run returns pointers to 00 (R1)
        @(negedge clk);
        idle(); rst_n = 1'b0;
        @(posedge clk); #1;
        rst_n = 1'b1;
        check("R1 ptr after reset", 32'({tm_ptr, al_ptr}), 32'd0);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (2000) @(posedge clk);
                n_chk++; n_fail++;
                $display("FAIL watchdog actual=timeout expected=completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule